// File: doc/BRIEF.md
# Physical Address Map Router

This block takes one physical memory access at a time and steers it to the target that owns the address. The targets are main DRAM, a read-only configuration ROM window, a timer, an interrupt controller, a serial port and a block-storage register window. A request carries an address, a size of 1, 2, 4 or 8 bytes, a read/write flag and write data. The block answers with read data or with an error flag.

Accesses that land wholly in DRAM leave the block as one transfer of the full size, with the address rebased to zero. Accesses to a peripheral window go out over a byte port, one little-endian byte per cycle. This also applies to DRAM accesses whose span wraps past the top of the address space. A mode input selects 32-bit addressing, in which only the low half of the address is decoded. The handshake is valid/ready, and one request is in flight at a time.

Top module: `phys_addr_router`

## Requirements
- R1: An effective address at or above 0x8000_0000 whose span does not wrap goes out as a single DRAM transfer. That transfer has dram_addr equal to the address minus 0x8000_0000 and dram_size equal to req_size. The response follows after exactly one busy cycle.
- R2: When mode32 is high at acceptance, address bits 63:32 are treated as zero, both for decoding and for the wrap test.
- R3: Reads at 0x1020..0x1FFF return ROM bytes over the byte port with target code 1 and offset equal to the address minus 0x1020. A write to this window ends with rsp_err and issues no strobe for that byte.
- R4: The byte port uses these target codes and address ranges: 2 for the timer (0x0200_0000..0x0200_FFFF), 3 for the interrupt controller (0x0C00_0000..0x0FFF_FFFF), 4 for the serial port (0x1000_0000..0x1000_00FF) and 5 for block storage (0x1000_1000..0x1000_1FFF). dev_offset is the address minus the window base.
- R5: Accesses that are not sent whole to DRAM issue byte i at address+i, one byte per cycle, with i counting up. Byte i carries data bits [8i+7:8i]. A response with all N bytes completed follows after N busy cycles.
- R6: A DRAM access whose last byte address overflows the active address width (64 bits, or 32 bits in 32-bit mode) is split into bytes. Each byte is decoded on its own, so bytes that wrap to low addresses are routed by their own address. A DRAM byte goes out with dram_size 0.
- R7: A byte at an unmapped address stops the access with rsp_err=1 and rsp_rdata=0 after k+1 busy cycles, where k is the index of that byte. Bytes before it have already been issued.
- R8: req_ready is high only when no request is held, so a second request is not accepted until the response has been taken.
- R9: rsp_valid, rsp_rdata and rsp_err hold steady until rsp_ready is seen high.
- R10: Read data above the requested size is returned as zero. Sizes are encoded as 0=1, 1=2, 2=4 and 3=8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 32-bit addressing mode, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Physical address |
| req_size | input | 2 | log2 of the access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DATA_W | Read data, zero-extended |
| rsp_err | output | 1 | Access error |
| dram_valid | output | 1 | DRAM transfer strobe |
| dram_addr | output | ADDR_W | Rebased DRAM address |
| dram_size | output | 2 | DRAM transfer size code |
| dram_write | output | 1 | DRAM write |
| dram_wdata | output | DATA_W | DRAM write data |
| dram_rdata | input | DATA_W | DRAM read data, same cycle |
| dev_valid | output | 1 | Byte port strobe |
| dev_tgt | output | 3 | Byte port target code |
| dev_offset | output | OFS_W | Offset within the target window |
| dev_write | output | 1 | Byte port write |
| dev_wdata | output | 8 | Byte port write data |
| dev_rdata | input | 8 | Byte port read data, same cycle |

## Verification
Two functions can act in the same cycle: issuing a byte, and detecting that the next byte address has left its window. This happens in the cycle where a multi-byte access steps off the end of a window, as with a 4-byte access at 0x1FFE, at 0x1000_00FE, or at the very top of the 64-bit or 32-bit space. The bench drives these edges directly and also hits them through random addresses clustered near window borders. For each case it predicts the error flag, the zeroed data, the busy-cycle count at which the access stops, and, for writes, which bytes of its stub memories did change.

// File: rtl/rtr_pkg.sv
`timescale 1ns/1ps
package rtr_pkg;

  typedef enum logic [2:0] {
    TGT_DRAM   = 3'd0,
    TGT_ROM    = 3'd1,
    TGT_TIMER  = 3'd2,
    TGT_INTC   = 3'd3,
    TGT_SERIAL = 3'd4,
    TGT_BLOCK  = 3'd5,
    TGT_NONE   = 3'd7
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } seq_st_e;

  localparam logic [63:0] DRAM_BASE = 64'h0000_0000_8000_0000;

  localparam int NWIN = 5;

  localparam logic [63:0] WIN_LO [NWIN] = '{
    64'h0000_1020, 64'h0200_0000, 64'h0C00_0000, 64'h1000_0000, 64'h1000_1000
  };

  localparam logic [63:0] WIN_HI [NWIN] = '{
    64'h0000_1FFF, 64'h0200_FFFF, 64'h0FFF_FFFF, 64'h1000_00FF, 64'h1000_1FFF
  };

  localparam tgt_e WIN_TGT [NWIN] = '{
    TGT_ROM, TGT_TIMER, TGT_INTC, TGT_SERIAL, TGT_BLOCK
  };

endpackage

// File: rtl/rtr_decode.sv
`timescale 1ns/1ps
module rtr_decode
  import rtr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFS_W  = 26
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [OFS_W-1:0]  ofs
);

  logic [63:0]      a64;
  logic [NWIN-1:0]  hit;
  logic [OFS_W-1:0] wofs [NWIN];

  assign a64 = 64'(addr);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w]  = (a64 >= WIN_LO[w]) && (a64 <= WIN_HI[w]);
    assign wofs[w] = OFS_W'(a64 - WIN_LO[w]);
  end

  always_comb begin
    tgt = TGT_NONE;
    ofs = '0;
    if (a64 >= DRAM_BASE) begin
      tgt = TGT_DRAM;
    end
    for (int w = 0; w < NWIN; w++) begin
      if (hit[w]) begin
        tgt = WIN_TGT[w];
        ofs = wofs[w];
      end
    end
  end

endmodule

// File: rtl/rtr_span.sv
`timescale 1ns/1ps
module rtr_span #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  idx,
  input  logic [CNT_W-1:0]  last_idx,
  input  logic              mode32,
  output logic [ADDR_W-1:0] cur,
  output logic              no_wrap
);

  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] sum;
  logic [ADDR_W:0]   end_full;
  logic [HALF:0]     end_half;

  assign sum      = base + ADDR_W'(idx);
  assign cur      = mode32 ? {{(ADDR_W-HALF){1'b0}}, sum[HALF-1:0]} : sum;
  assign end_full = {1'b0, base} + (ADDR_W+1)'(last_idx);
  assign end_half = {1'b0, base[HALF-1:0]} + (HALF+1)'(last_idx);
  assign no_wrap  = mode32 ? !end_half[HALF] : !end_full[ADDR_W];

endmodule

// File: rtl/rtr_seq.sv
`timescale 1ns/1ps
module rtr_seq
  import rtr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int SZ_W   = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode32,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] base_o,
  output logic              mode32_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic [CNT_W-1:0]  last_o,
  input  tgt_e              tgt,
  input  logic              no_wrap,
  output logic              dram_valid,
  output logic [SZ_W-1:0]   dram_size,
  output logic              dram_write,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              dev_valid,
  output logic              dev_write,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);

  localparam int NB   = DATA_W / 8;
  localparam int HALF = ADDR_W / 2;

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] base_q;
  logic              mode32_q;
  logic [SZ_W-1:0]   size_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              err_q, err_d;

  logic              busy, accept, fast, bad, byte_dram, byte_dev, last;
  logic              cnt_en, data_en, err_en;
  logic [CNT_W-1:0]  last_idx;
  logic [7:0]        wbyte, rbyte;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [CNT_W-1:0] li);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < NB; b++) begin
      if (CNT_W'(b) <= li) m[8*b +: 8] = 8'hFF;
    end
    return m;
  endfunction

  assign busy      = (st_q == ST_BUSY);
  assign accept    = req_valid && (st_q == ST_IDLE);
  assign last_idx  = CNT_W'((1 << size_q) - 1);
  assign fast      = busy && (idx_q == '0) && (tgt == TGT_DRAM) && no_wrap;
  assign bad       = busy && !fast &&
                     ((tgt == TGT_NONE) || ((tgt == TGT_ROM) && write_q));
  assign byte_dram = busy && !fast && !bad && (tgt == TGT_DRAM);
  assign byte_dev  = busy && !fast && !bad && (tgt != TGT_DRAM);
  assign last      = busy && (fast || bad || (idx_q == last_idx));

  assign wbyte     = 8'(wdata_q >> {idx_q, 3'b000});
  assign rbyte     = byte_dram ? dram_rdata[7:0] : dev_rdata;

  // Transfer outputs
  assign dram_valid = fast || byte_dram;
  assign dram_size  = fast ? size_q : '0;
  assign dram_write = write_q;
  assign dram_wdata = fast ? wdata_q : DATA_W'(wbyte);
  assign dev_valid  = byte_dev;
  assign dev_write  = write_q;
  assign dev_wdata  = wbyte;

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = err_q ? '0 : data_q;
  assign rsp_err   = err_q;

  assign base_o   = base_q;
  assign mode32_o = mode32_q;
  assign idx_o    = idx_q;
  assign last_o   = last_idx;

  // Next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_BUSY;
      ST_BUSY: if (last)      st_d = ST_RESP;
      ST_RESP: if (rsp_ready) st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    idx_d  = accept ? '0 : idx_q + 1'b1;
    err_d  = !accept;
    if (accept) begin
      data_d = '0;
    end else if (fast) begin
      data_d = dram_rdata & lane_mask(last_idx);
    end else begin
      data_d = data_q | (DATA_W'(rbyte) << {idx_q, 3'b000});
    end
  end

  assign cnt_en  = accept || (busy && !last);
  assign data_en = accept || (busy && !write_q && (fast || byte_dram || byte_dev));
  assign err_en  = accept || bad;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      mode32_q <= 1'b0;
      size_q   <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      idx_q    <= '0;
      data_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        base_q   <= mode32 ? {{(ADDR_W-HALF){1'b0}}, req_addr[HALF-1:0]} : req_addr;
        mode32_q <= mode32;
        size_q   <= req_size;
        write_q  <= req_write;
        wdata_q  <= req_wdata;
      end
      if (cnt_en)  idx_q  <= idx_d;
      if (data_en) data_q <= data_d;
      if (err_en)  err_q  <= err_d;
    end
  end

  // R8: an accepted request blocks further acceptance next cycle
  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: response held while not taken
  a_r9_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R5: never two transfers in one cycle
  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dram_valid, dev_valid}));

  // R1: a multi-byte DRAM transfer completes the request
  a_r1_full_once: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_valid && (dram_size != '0)) |=> rsp_valid);

endmodule

// File: rtl/phys_addr_router.sv
`timescale 1ns/1ps
module phys_addr_router
  import rtr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int OFS_W  = 26,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode32,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              dram_valid,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [SZ_W-1:0]   dram_size,
  output logic              dram_write,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              dev_valid,
  output logic [2:0]        dev_tgt,
  output logic [OFS_W-1:0]  dev_offset,
  output logic              dev_write,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);

  localparam int CNT_W = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] base, cur;
  logic              mode32_q, no_wrap;
  logic [CNT_W-1:0]  idx, last_idx;
  tgt_e              tgt;
  logic [OFS_W-1:0]  ofs;

  rtr_span #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_span (
    .base     (base),
    .idx      (idx),
    .last_idx (last_idx),
    .mode32   (mode32_q),
    .cur      (cur),
    .no_wrap  (no_wrap)
  );

  rtr_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_decode (
    .addr (cur),
    .tgt  (tgt),
    .ofs  (ofs)
  );

  rtr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SZ_W(SZ_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode32     (mode32),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .base_o     (base),
    .mode32_o   (mode32_q),
    .idx_o      (idx),
    .last_o     (last_idx),
    .tgt        (tgt),
    .no_wrap    (no_wrap),
    .dram_valid (dram_valid),
    .dram_size  (dram_size),
    .dram_write (dram_write),
    .dram_wdata (dram_wdata),
    .dram_rdata (dram_rdata),
    .dev_valid  (dev_valid),
    .dev_write  (dev_write),
    .dev_wdata  (dev_wdata),
    .dev_rdata  (dev_rdata)
  );

  assign dram_addr  = cur - ADDR_W'(DRAM_BASE);
  assign dev_tgt    = tgt;
  assign dev_offset = ofs;

  // R3: the ROM window never sees a write strobe
  a_r3_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && (dev_tgt == 3'(TGT_ROM))) |-> !dev_write);

  // R7: nothing is issued while a response is pending
  a_r7_quiet_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(dram_valid || dev_valid));

endmodule

// File: tb/phys_addr_router_tb.sv
`timescale 1ns/1ps
module phys_addr_router_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode32, req_valid, req_ready, req_write;
  logic [63:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_ready, rsp_err;
  logic [63:0] rsp_rdata;
  logic        dram_valid, dram_write;
  logic [63:0] dram_addr, dram_wdata, dram_rdata;
  logic [1:0]  dram_size;
  logic        dev_valid, dev_write;
  logic [2:0]  dev_tgt;
  logic [25:0] dev_offset;
  logic [7:0]  dev_wdata, dev_rdata;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [7:0] dmem  [0:4095];
  logic [7:0] sdmem [0:4095];
  logic [7:0] pmem  [0:7][0:255];
  logic [7:0] spmem [0:7][0:255];

  always #2 clk = ~clk;

  phys_addr_router u_dut (
    .clk(clk), .rst_n(rst_n), .mode32(mode32),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .dram_valid(dram_valid), .dram_addr(dram_addr), .dram_size(dram_size),
    .dram_write(dram_write), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .dev_valid(dev_valid), .dev_tgt(dev_tgt), .dev_offset(dev_offset),
    .dev_write(dev_write), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  function automatic logic [7:0] rom_byte(input logic [11:0] off);
    return off[7:0] ^ {off[11:8], 4'h5};
  endfunction

  // Stub targets
  always_comb begin
    for (int i = 0; i < 8; i++) dram_rdata[8*i +: 8] = dmem[dram_addr[11:0] + 12'(i)];
  end
  always_comb begin
    dev_rdata = (dev_tgt == 3'd1) ? rom_byte(dev_offset[11:0]) : pmem[dev_tgt][dev_offset[7:0]];
  end
  always @(posedge clk) begin
    if (dram_valid && dram_write)
      for (int i = 0; i < 8; i++)
        if (i < (1 << dram_size)) dmem[dram_addr[11:0] + 12'(i)] <= dram_wdata[8*i +: 8];
    if (dev_valid && dev_write) pmem[dev_tgt][dev_offset[7:0]] <= dev_wdata;
  end

  // Bench address map, written from the requirements
  function automatic logic [2:0] b_tgt(input logic [63:0] a);
    if (a >= 64'h8000_0000) return 3'd0;
    if (a >= 64'h1020 && a <= 64'h1FFF) return 3'd1;
    if (a >= 64'h0200_0000 && a <= 64'h0200_FFFF) return 3'd2;
    if (a >= 64'h0C00_0000 && a <= 64'h0FFF_FFFF) return 3'd3;
    if (a >= 64'h1000_0000 && a <= 64'h1000_00FF) return 3'd4;
    if (a >= 64'h1000_1000 && a <= 64'h1000_1FFF) return 3'd5;
    return 3'd7;
  endfunction

  function automatic logic [63:0] b_lo(input logic [2:0] t);
    case (t)
      3'd1: return 64'h1020;
      3'd2: return 64'h0200_0000;
      3'd3: return 64'h0C00_0000;
      3'd4: return 64'h1000_0000;
      3'd5: return 64'h1000_1000;
      default: return 64'h8000_0000;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [1:0] sz, input logic wr,
                        input logic [63:0] wd, input logic m32, input string tag, input bit hold);
    logic [63:0] e, b, r, exp_data, d0;
    logic [64:0] s65;
    logic [32:0] s33;
    logic [2:0]  t;
    logic        exp_err, fast, ready_ok, e0;
    int          n, exp_cyc, cyc, mism;
    n = 1 << sz;
    e = m32 ? {32'h0, a[31:0]} : a;
    s65 = {1'b0, e} + 65'(n - 1);
    s33 = {1'b0, e[31:0]} + 33'(n - 1);
    fast = (b_tgt(e) == 3'd0) && (m32 ? !s33[32] : !s65[64]);
    exp_err = 1'b0;
    exp_data = '0;
    exp_cyc = fast ? 1 : n;
    for (int i = 0; i < n; i++) begin
      b = e + 64'(i);
      if (m32) b[63:32] = '0;
      t = fast ? 3'd0 : b_tgt(b);
      if (t == 3'd7 || (t == 3'd1 && wr)) begin
        exp_err = 1'b1;
        exp_cyc = i + 1;
        break;
      end
      if (t == 3'd0) begin
        r = b - 64'h8000_0000;
        if (wr) sdmem[r[11:0]] = wd[8*i +: 8];
        else    exp_data[8*i +: 8] = sdmem[r[11:0]];
      end else if (t == 3'd1) begin
        r = b - 64'h1020;
        exp_data[8*i +: 8] = rom_byte(r[11:0]);
      end else begin
        r = b - b_lo(t);
        if (wr) spmem[t][r[7:0]] = wd[8*i +: 8];
        else    exp_data[8*i +: 8] = spmem[t][r[7:0]];
      end
    end
    if (exp_err || wr) exp_data = '0;

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; mode32 = m32; rsp_ready = !hold;
    @(posedge clk);
    #1 req_valid = 1'b0;
    cyc = 0;
    ready_ok = 1'b1;
    while (1) begin
      @(negedge clk);
      if (rsp_valid) break;
      if (req_ready) ready_ok = 1'b0;
      cyc++;
      if (cyc > 64) break;
    end
    chk(tag, "error flag", 64'(rsp_err), 64'(exp_err));
    chk(tag, "read data", rsp_rdata, exp_data);
    chk(tag, "busy cycles", 64'(cyc), 64'(exp_cyc));
    chk("R8", "ready low while busy", 64'(ready_ok), 64'd1);
    if (hold) begin
      d0 = rsp_rdata;
      e0 = rsp_err;
      repeat (3) @(negedge clk);
      chk("R9", "held valid", 64'(rsp_valid), 64'd1);
      chk("R9", "held data", rsp_rdata, d0);
      chk("R9", "held err", 64'(rsp_err), 64'(e0));
      rsp_ready = 1'b1;
      @(negedge clk);
    end
    if (wr) begin
      mism = 0;
      for (int i = 0; i < 4096; i++) if (dmem[i] !== sdmem[i]) mism++;
      for (int k = 0; k < 8; k++)
        for (int j = 0; j < 256; j++) if (pmem[k][j] !== spmem[k][j]) mism++;
      chk(tag, "stub memory mismatches", 64'(mism), 64'd0);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, wd;
    logic [1:0]  sz;
    logic        wr, m32;
    string       tag;
    int          seed;
    seed = $urandom(32'h5eed_1234);
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_wdata = '0; mode32 = 1'b0; rsp_ready = 1'b1;
    for (int i = 0; i < 4096; i++) begin
      dmem[i] <= 8'(i * 37 + 1);
      sdmem[i] = 8'(i * 37 + 1);
    end
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 256; j++) begin
        pmem[k][j] <= 8'(k * 50 + j * 3);
        spmem[k][j] = 8'(k * 50 + j * 3);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reset req_ready", 64'(req_ready), 64'd1);
    chk("R9", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R5", "reset strobes", 64'({dram_valid, dev_valid}), 64'd0);

    // Directed corners
    run_op(64'h8000_0010, 2'd3, 1'b0, '0, 1'b0, "R1", 1'b0);
    run_op(64'h8000_0100, 2'd2, 1'b1, 64'h1122_3344_5566_7788, 1'b0, "R1", 1'b0);
    run_op(64'h8000_0100, 2'd3, 1'b0, '0, 1'b0, "R1", 1'b0);
    run_op(64'h8000_0000, 2'd0, 1'b0, '0, 1'b0, "R10", 1'b0);
    run_op(64'h7FFF_FFFF, 2'd0, 1'b0, '0, 1'b0, "R7", 1'b0);
    run_op(64'hABCD_0000_8000_0020, 2'd3, 1'b0, '0, 1'b1, "R2", 1'b0);
    run_op(64'h1234_5678_0000_1020, 2'd2, 1'b0, '0, 1'b1, "R2", 1'b0);
    run_op(64'h0000_0001_0000_1020, 2'd0, 1'b0, '0, 1'b0, "R2", 1'b0);
    run_op(64'h1020, 2'd2, 1'b0, '0, 1'b0, "R3", 1'b0);
    run_op(64'h1040, 2'd0, 1'b1, 64'hFF, 1'b0, "R3", 1'b0);
    run_op(64'h1FFE, 2'd2, 1'b0, '0, 1'b0, "R7", 1'b0);
    run_op(64'h101F, 2'd0, 1'b0, '0, 1'b0, "R7", 1'b0);
    run_op(64'h1000_00FC, 2'd2, 1'b1, 64'hDEAD_BEEF, 1'b0, "R5", 1'b0);
    run_op(64'h1000_00FC, 2'd2, 1'b0, '0, 1'b0, "R5", 1'b0);
    run_op(64'h1000_00FE, 2'd2, 1'b1, 64'hCAFE_F00D, 1'b0, "R7", 1'b0);
    run_op(64'h0200_FFF8, 2'd3, 1'b0, '0, 1'b0, "R4", 1'b0);
    run_op(64'h0C00_0040, 2'd3, 1'b1, 64'h0102_0304_0506_0708, 1'b0, "R4", 1'b0);
    run_op(64'h0C00_0040, 2'd3, 1'b0, '0, 1'b0, "R4", 1'b0);
    run_op(64'h1000_1FF0, 2'd1, 1'b0, '0, 1'b0, "R10", 1'b0);
    run_op(64'hFFFF_FFFF_FFFF_FFFC, 2'd3, 1'b0, '0, 1'b0, "R6", 1'b0);
    run_op(64'hFFFF_FFFF_FFFF_FFFC, 2'd2, 1'b0, '0, 1'b0, "R6", 1'b0);
    run_op(64'h0000_0000_FFFF_FFFE, 2'd1, 1'b0, '0, 1'b1, "R6", 1'b0);
    run_op(64'h0000_0000_FFFF_FFFE, 2'd2, 1'b1, 64'h5A5A_A5A5, 1'b1, "R6", 1'b0);
    run_op(64'h8000_0200, 2'd3, 1'b0, '0, 1'b0, "R9", 1'b1);
    run_op(64'h0000_0005, 2'd0, 1'b0, '0, 1'b0, "R9", 1'b1);

    // Constrained random
    for (int it = 0; it < 300; it++) begin
      sz  = 2'($urandom % 4);
      wr  = ($urandom % 2) == 0;
      wd  = {$urandom, $urandom};
      m32 = ($urandom % 4) == 0;
      case ($urandom % 8)
        0: begin a = 64'h8000_0000 + 64'($urandom % 4096); tag = "R1"; end
        1: begin a = 64'h1020 + 64'($urandom % 32'hFE0); if ($urandom % 2) a = 64'h1FF8 + 64'($urandom % 8); tag = "R3"; end
        2: begin a = 64'h0200_0000 + (($urandom % 2) ? 64'($urandom % 16) : 64'h0000_FFF0 + 64'($urandom % 16)); tag = "R4"; end
        3: begin a = 64'h0C00_0000 + 64'($urandom % 256); tag = "R4"; end
        4: begin a = 64'h1000_0000 + 64'($urandom % 256); tag = "R5"; end
        5: begin a = 64'h1000_1000 + 64'($urandom % 4096); tag = "R5"; end
        6: begin a = 64'hFFFF_FFFF_FFFF_FFF8 + 64'($urandom % 8); tag = "R6"; end
        default: begin a = 64'($urandom % 32'h1020); tag = "R7"; end
      endcase
      if (m32) begin
        a[63:32] = $urandom;
        tag = "R2";
      end
      run_op(a, sz, wr, wd, m32, tag, 1'b0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule